// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches one pin's already-filtered input level and turns it into a sticky interrupt status bit and a masked interrupt request. Software configures it with four controls. A trigger-style bit selects edge or level sensitivity. A 2-bit sense field selects low/falling, high/rising or both edges. A detect-enable bit decides whether events are latched. A separate pass bit decides whether a latched status is forwarded as a request. Because detection and delivery are gated independently, an event can be recorded while its delivery is held back, and it is released later by setting the pass bit.

A write-one-to-clear strobe removes the status. No other acknowledge step exists: clearing the status is all a handler has to do. In level mode the status is set again on every clock while the configured level remains present, so a clear takes effect only once the pin has gone inactive. The request output feeds a shared interrupt aggregator.

Top module: `pin_irq_detect`

## Requirements
- R1: After synchronous reset, status_o and irq_o are 0. No edge is reported on the first clock after reset, whatever level pin_i has at that clock.
- R2: With lvl_mode_i=0 and sense_i=01, a 0-to-1 change of pin_i between two consecutive clock edges sets status_o at the second of those edges.
- R3: With lvl_mode_i=0 and sense_i=00, a 1-to-0 change of pin_i sets status_o at the clock edge that samples the new level.
- R4: With lvl_mode_i=0 and sense_i=10, both rising and falling changes of pin_i set status_o.
- R5: sense_i=11 never sets status_o, in either mode. In level mode, sense_i=10 also never sets status_o.
- R6: With lvl_mode_i=1, status_o is set at every clock edge where pin_i is at the active level: 1 for sense_i=01, 0 for sense_i=00.
- R7: status_o stays at 1 until a clock edge with clr_i=1. That edge clears it only if no new event is detected at the same edge; a detected event wins over the clear.
- R8: While irq_en_i=0, no event sets status_o. A status that is already set keeps its value.
- R9: irq_o equals status_o AND irq_en_i AND irq_pass_i. With irq_pass_i=0, events still latch into status_o but irq_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Filtered pin level |
| lvl_mode_i | input | 1 | 1 = level sensitive, 0 = edge sensitive |
| sense_i | input | 2 | 00 low/falling, 01 high/rising, 10 both edges, 11 reserved |
| irq_en_i | input | 1 | Allows events to latch into status |
| irq_pass_i | input | 1 | 1 = forward status as a request |
| clr_i | input | 1 | Write-one-to-clear strobe for status |
| status_o | output | 1 | Sticky interrupt status |
| irq_o | output | 1 | Masked interrupt request to the aggregator |

## Verification
The assertions assume that pin_i is already synchronous to clk and that it is filtered, so every change of pin_i counts as a true edge. They also assume that configuration changes may land on any cycle, together with a pin change or a clear. The stimulus drives every input half a cycle away from the active edge. It mixes directed sequences with a pseudo-random phase in which pin, mode, sense, enable, pass and clear change freely, and this phase includes the reserved sense code. A behavioural model in the bench predicts status_o and irq_o for every cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_BOTH = 2'b10,
        SENSE_RSVD = 2'b11
    } sense_e;

    typedef struct packed {
        logic   lvl_mode;
        sense_e sense;
    } trig_cfg_t;

    // Edge qualification for the selected sense.
    function automatic logic edge_qualifies(sense_e s, logic rise, logic fall);
        logic r;
        case (s)
            SENSE_LOW:  r = fall;
            SENSE_HIGH: r = rise;
            SENSE_BOTH: r = rise | fall;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

    // Level qualification; both-edge and reserved codes never match a level.
    function automatic logic level_qualifies(sense_e s, logic pin);
        logic r;
        case (s)
            SENSE_LOW:  r = ~pin;
            SENSE_HIGH: r = pin;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pin_event_det.sv
module pin_event_det
    import pin_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  trig_cfg_t cfg_i,
    output logic      hit_o
);

    logic prev_q;
    logic primed_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= pin_i;
            primed_q <= 1'b1;
        end
    end

    assign rise = primed_q & pin_i & ~prev_q;
    assign fall = primed_q & ~pin_i & prev_q;

    always_comb begin
        if (cfg_i.lvl_mode)
            hit_o = level_qualifies(cfg_i.sense, pin_i);
        else
            hit_o = edge_qualifies(cfg_i.sense, rise, fall);
    end

    AST_RISE_SEEN: assert property (@(posedge clk) disable iff (rst)
        (primed_q && !cfg_i.lvl_mode && cfg_i.sense == SENSE_HIGH && $rose(pin_i)) |-> hit_o) // R2
        else $error("rising edge missed");

    AST_FALL_SEEN: assert property (@(posedge clk) disable iff (rst)
        (primed_q && !cfg_i.lvl_mode && cfg_i.sense == SENSE_LOW && $fell(pin_i)) |-> hit_o) // R3
        else $error("falling edge missed");

    AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (primed_q && !cfg_i.lvl_mode && $stable(pin_i)) |-> !hit_o) // R2
        else $error("edge reported on a stable pin");

    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.sense == SENSE_RSVD) |-> !hit_o) // R5
        else $error("reserved sense produced an event");

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic en_i,
    input  logic clr_i,
    output logic status_o
);

    logic status_q;

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= 1'b0;
        else
            status_q <= (status_q & ~clr_i) | (en_i & hit_i);
    end

    assign status_o = status_q;

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status_q && !clr_i) |=> status_q) // R7
        else $error("status dropped without clear");

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !(en_i && hit_i)) |=> !status_q) // R7
        else $error("clear ignored");

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !status_q) |=> !status_q) // R8
        else $error("status set while disabled");

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (en_i && hit_i) |=> status_q) // R7
        else $error("event lost");

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
    import pin_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_i,
    input  logic       lvl_mode_i,
    input  logic [1:0] sense_i,
    input  logic       irq_en_i,
    input  logic       irq_pass_i,
    input  logic       clr_i,
    output logic       status_o,
    output logic       irq_o
);

    trig_cfg_t cfg;
    logic      hit;
    logic      status;

    assign cfg.lvl_mode = lvl_mode_i;
    assign cfg.sense    = sense_e'(sense_i);

    pin_event_det u_det (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_i),
        .cfg_i (cfg),
        .hit_o (hit)
    );

    irq_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .hit_i    (hit),
        .en_i     (irq_en_i),
        .clr_i    (clr_i),
        .status_o (status)
    );

    assign status_o = status;
    assign irq_o    = status & irq_en_i & irq_pass_i;

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lvl_mode_i && sense_i == 2'b01 && pin_i && irq_en_i) |=> status_o) // R6
        else $error("active level not latched");

    AST_REQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (!$past(status_o) && !$past(irq_en_i)) |-> !irq_o) // R9
        else $error("request without latched status");

endmodule

// File: tb/pin_irq_detect_tb.sv
module pin_irq_detect_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin = 1'b0, lvl = 1'b0, en = 1'b0, pass = 1'b0, clr = 1'b0;
    logic [1:0] sense = 2'b01;
    logic       status_w, irq_w;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state
    bit m_st = 0, m_prev = 0, m_valid = 0;

    always #2.5 clk = ~clk;

    pin_irq_detect dut_i (
        .clk(clk), .rst(rst), .pin_i(pin), .lvl_mode_i(lvl), .sense_i(sense),
        .irq_en_i(en), .irq_pass_i(pass), .clr_i(clr),
        .status_o(status_w), .irq_o(irq_w)
    );

    function automatic bit model_event(bit p);
        bit e = 0;
        if (lvl) begin
            if (sense == 2'b01) e = p;
            else if (sense == 2'b00) e = !p;
        end else if (m_valid) begin
            if (sense == 2'b01) e = p && !m_prev;
            else if (sense == 2'b00) e = !p && m_prev;
            else if (sense == 2'b10) e = p != m_prev;
        end
        return e;
    endfunction

    task automatic compare(string tag);
        bit exp_irq = m_st && en && pass;
        checks++;
        if (status_w !== m_st) begin
            errors++;
            $display("FAIL %s status: got %b expected %b", tag, status_w, m_st);
        end
        checks++;
        if (irq_w !== exp_irq) begin
            errors++;
            $display("FAIL %s irq: got %b expected %b", tag, irq_w, exp_irq);
        end
    endtask

    // one clock: drive at negedge, update model at posedge, sample 1 ns later
    task automatic step(input bit p, input bit l, input bit [1:0] s, input bit e,
                        input bit m, input bit c, input string tag);
        bit ev;
        @(negedge clk);
        pin = p; lvl = l; sense = s; en = e; pass = m; clr = c;
        @(posedge clk);
        ev = model_event(p);
        m_st = (m_st && !c) || (e && ev);
        m_prev = p;
        m_valid = 1;
        #1;
        compare(tag);
    endtask

    task automatic do_reset(input bit p);
        @(negedge clk);
        rst = 1; pin = p;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_st = 0; m_valid = 0; m_prev = 0;
        #1;
        compare("R1_reset");
    endtask

    initial begin
        #(5.0 * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr = 16'hACE1;
        // R1: pin high at reset, no false edge
        do_reset(1);
        step(1, 0, 2'b01, 1, 1, 0, "R1_no_first_edge");
        // R2 rising
        step(0, 0, 2'b01, 1, 1, 0, "R2_low");
        step(1, 0, 2'b01, 1, 1, 0, "R2_rise");
        step(1, 0, 2'b01, 1, 1, 0, "R7_hold");
        step(1, 0, 2'b01, 1, 1, 0, "R7_hold2");
        step(1, 0, 2'b01, 1, 1, 1, "R7_clear");
        // R9 pass gating
        step(0, 0, 2'b01, 1, 0, 0, "R9_low");
        step(1, 0, 2'b01, 1, 0, 0, "R9_latched_blocked");
        step(1, 0, 2'b01, 1, 1, 0, "R9_released");
        step(1, 0, 2'b01, 0, 1, 0, "R9_en_off");
        step(1, 0, 2'b01, 1, 1, 1, "R7_clear2");
        // R3 falling
        step(0, 0, 2'b00, 1, 1, 0, "R3_fall");
        step(0, 0, 2'b00, 1, 1, 1, "R3_clear");
        step(1, 0, 2'b00, 1, 1, 0, "R3_rise_ignored");
        // R4 both edges
        step(0, 0, 2'b10, 1, 1, 0, "R4_fall");
        step(0, 0, 2'b10, 1, 1, 1, "R4_clear");
        step(1, 0, 2'b10, 1, 1, 0, "R4_rise");
        // R7 set wins over clear
        step(0, 0, 2'b10, 1, 1, 1, "R7_set_wins");
        step(0, 0, 2'b10, 1, 1, 1, "R7_clear3");
        // R5 reserved code, edge and level
        step(1, 0, 2'b11, 1, 1, 0, "R5_rsvd_edge_r");
        step(0, 0, 2'b11, 1, 1, 0, "R5_rsvd_edge_f");
        step(1, 1, 2'b11, 1, 1, 0, "R5_rsvd_lvl_h");
        step(0, 1, 2'b11, 1, 1, 0, "R5_rsvd_lvl_l");
        step(1, 1, 2'b10, 1, 1, 0, "R5_both_lvl_h");
        step(0, 1, 2'b10, 1, 1, 0, "R5_both_lvl_l");
        // R6 level high and low
        step(1, 1, 2'b01, 1, 1, 0, "R6_high_set");
        step(1, 1, 2'b01, 1, 1, 1, "R6_clear_blocked");
        step(0, 1, 2'b01, 1, 1, 0, "R6_inactive_hold");
        step(0, 1, 2'b01, 1, 1, 1, "R6_clear_ok");
        step(0, 1, 2'b00, 1, 1, 0, "R6_low_set");
        step(1, 1, 2'b00, 1, 1, 1, "R6_low_clear");
        // R8 enable off
        step(0, 0, 2'b01, 0, 1, 0, "R8_prep");
        step(1, 0, 2'b01, 0, 1, 0, "R8_edge_ignored");
        step(1, 1, 2'b01, 0, 1, 0, "R8_level_ignored");
        step(1, 1, 2'b01, 1, 1, 0, "R8_level_enabled");
        step(1, 1, 2'b01, 0, 1, 0, "R8_status_kept");
        step(0, 0, 2'b01, 0, 1, 1, "R8_clear");
        // mixed pseudo-random phase, all requirements
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[3] & lfsr[7], lfsr[5:4], lfsr[8] | lfsr[9],
                 lfsr[11] | lfsr[2], lfsr[12] & lfsr[1], "R9_mixed");
        end
        do_reset(0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule